// File: doc/BRIEF.md
# Network Controller Power-State Sequencer

This block sequences the power states of an Ethernet controller. It has three resting states: normal operation, wake-on-LAN sleep and energy-detect sleep. A fourth, transient state restarts the clocks after a wake. Software drives the block through a small register interface. It writes a two-bit power-mode field to enter a sleep state. It reads a ready flag. It reads and clears a wake-status field and a wake interrupt bit. The block drives clock-enable outputs for the MAC and host domains, a low-power request to the PHY and a wake (PME) output. It takes a carrier-detect level from the PHY.

In energy-detect sleep, a carrier seen by the PHY is recorded as a wake event. The interrupt bit is always set on such an event. The PME output is raised only when two enable bits allow it. Any write to a dedicated wake register brings the block back from either sleep state. The clocks restart, and after a fixed number of cycles the ready flag returns. Until it returns, reads are the only legal accesses. Any other write is dropped and recorded in a sticky error bit.

Register layout (host address, bit: meaning): address 0 is the control register. Bits [1:0] hold the mode (00 normal, 01 wake-on-LAN sleep, 10 energy-detect sleep, 11 reserved). Bit 2 is the energy-detect enable and bit 3 the PME enable. Bit 4 is ready, read-only. Bits [6:5] are the wake status (write one to clear). Bit 7 is the access error (write one to clear). Address 1 is the interrupt register, with the wake interrupt in bit 0 (write one to clear). Address 2 is the wake register: any write to it wakes the block, and it reads as zero.

Top module: `netPwrSeq`

## Requirements
- R1: After reset, the control register reads 0x10 (mode 00, ready 1) and the interrupt register reads 0. Both clock enables are 1, and phyLowPwr and pme are 0.
- R2: A control write with mode 10 while ready takes effect at the next clock edge. Ready falls, both clock enables fall, phyLowPwr rises and the mode field reads 10.
- R3: A control write with mode 01 while ready enters wake-on-LAN sleep. Ready and both clock enables fall and phyLowPwr stays 0. Carrier in this state sets neither the wake status nor the interrupt bit.
- R4: In energy-detect sleep, a carrier rising at the input is recognised after SYNC_STAGES+1 clock edges. The wake status becomes 01 and the interrupt bit becomes 1.
- R5: If carrier is already present when energy-detect sleep is entered, detection takes effect one clock edge after entry.
- R6: On detection, pme is asserted only when both the energy-detect enable (bit 2) and the PME enable (bit 3) are 1. The interrupt bit is set in every case.
- R7: A write to the wake register from either sleep state turns both clock enables on and drops phyLowPwr at the next edge. The mode field is reset to 00. Ready returns exactly WAKE_CYCLES edges after the write edge.
- R8: While ready is 0, every write other than one to the wake register is dropped and sets the access-error bit (bit 7). The bit stays set until cleared by writing one to it.
- R9: Writing one to the wake-status bits, to the access-error bit or to the interrupt bit clears that bit. Clearing the interrupt bit also drops pme.
- R10: A control write with the reserved mode 11 leaves the block in normal operation with the mode field at 00.
- R11: A write to the wake register while in normal operation has no effect: ready and both clock enables stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write strobe, one cycle per write |
| hostAddr | input | ADDR_W | Host register address for reads and writes |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Read data for hostAddr, combinational |
| carrierIn | input | 1 | Carrier-detect level from the PHY |
| macClkEn | output | 1 | MAC clock enable |
| hostClkEn | output | 1 | Host interface clock enable |
| phyLowPwr | output | 1 | PHY energy-detect low-power request |
| pme | output | 1 | Wake output |
| ready | output | 1 | Ready flag, also readable at control bit 4 |

## Verification
Suppose the sequencer state went wrong. The clock enables, phyLowPwr and ready would then disagree within one cycle of the write that caused it. A wake counter that is off by one shows up as ready rising one edge early or late, so the bench samples the edge before and the edge of the expected rise. Faults in the detection path show in the interrupt and wake-status bits, which remain readable during sleep. The bench reads them on the edge before and the edge of the expected detection. A fault in write gating shows as a control field that changed, or an error bit that stayed 0, after a write made while ready was low.

// File: rtl/pwrSeqPkg.sv
package pwrSeqPkg;

  typedef enum logic [1:0] {
    PS_ON     = 2'd0,
    PS_WOL    = 2'd1,
    PS_ED     = 2'd2,
    PS_WAKING = 2'd3
  } pwrState_t;

  localparam logic [1:0] MODE_ON  = 2'b00;
  localparam logic [1:0] MODE_WOL = 2'b01;
  localparam logic [1:0] MODE_ED  = 2'b10;

  localparam int REG_CTRL = 0;
  localparam int REG_INT  = 1;
  localparam int REG_WAKE = 2;

  // control register bit positions
  localparam int B_ED_EN  = 2;
  localparam int B_PME_EN = 3;
  localparam int B_READY  = 4;
  localparam int B_WST_LO = 5;
  localparam int B_ERR    = 7;

  typedef struct packed {
    logic ctrlWr;   // legal control write
    logic intWr;    // legal interrupt register write
    logic wake;     // wake write from a sleep state
    logic detect;   // carrier detected in energy-detect sleep
    logic badWr;    // write dropped while not ready
  } pwrStrobes_t;

endpackage

// File: rtl/carrierSync.sv
module carrierSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= asyncIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pwrSeqCtrl.sv
module pwrSeqCtrl
  import pwrSeqPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int WAKE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        wrMode,
  input  logic              carrierSync,
  output pwrStrobes_t       strb,
  output logic              ready,
  output logic              macClkEn,
  output logic              hostClkEn,
  output logic              phyLowPwr
);
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

  pwrState_t  state;
  logic [CNT_W-1:0] wakeCnt;
  logic isCtrl, isInt, isWake, asleep;

  assign isCtrl = (hostAddr == ADDR_W'(REG_CTRL));
  assign isInt  = (hostAddr == ADDR_W'(REG_INT));
  assign isWake = (hostAddr == ADDR_W'(REG_WAKE));
  assign asleep = (state == PS_WOL) || (state == PS_ED);

  always_comb begin
    strb        = '0;
    strb.ctrlWr = hostWrEn && isCtrl && (state == PS_ON);
    strb.intWr  = hostWrEn && isInt  && (state == PS_ON);
    strb.wake   = hostWrEn && isWake && asleep;
    strb.badWr  = hostWrEn && !isWake && (state != PS_ON);
    strb.detect = (state == PS_ED) && carrierSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PS_ON;
      wakeCnt <= '0;
    end else begin
      case (state)
        PS_ON: begin
          if (strb.ctrlWr && wrMode == MODE_ED)       state <= PS_ED;
          else if (strb.ctrlWr && wrMode == MODE_WOL) state <= PS_WOL;
        end
        PS_WOL, PS_ED: begin
          if (strb.wake) begin
            state   <= PS_WAKING;
            wakeCnt <= CNT_W'(WAKE_CYCLES - 1);
          end
        end
        PS_WAKING: begin
          if (wakeCnt == '0) state <= PS_ON;
          else               wakeCnt <= wakeCnt - 1'b1;
        end
        default: state <= PS_ON;
      endcase
    end
  end

  assign ready     = (state == PS_ON);
  assign macClkEn  = !asleep;
  assign hostClkEn = !asleep;
  assign phyLowPwr = (state == PS_ED);
endmodule

// File: rtl/pwrSeqData.sv
module pwrSeqData
  import pwrSeqPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwrStrobes_t       strb,
  input  logic              ready,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              pme,
  output logic [1:0]        modeQ,
  output logic              edEnQ,
  output logic              pmeEnQ,
  output logic              pmeIntQ,
  output logic              accErrQ,
  output logic [1:0]        wakeStQ
);
  logic [7:0] wd;
  assign wd = hostWrData[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_ON;
      edEnQ   <= 1'b0;
      pmeEnQ  <= 1'b0;
      wakeStQ <= 2'b00;
      accErrQ <= 1'b0;
      pmeIntQ <= 1'b0;
      pme     <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        if (wd[1:0] == MODE_ED || wd[1:0] == MODE_WOL) modeQ <= wd[1:0];
        edEnQ  <= wd[B_ED_EN];
        pmeEnQ <= wd[B_PME_EN];
        if (wd[B_WST_LO])   wakeStQ[0] <= 1'b0;
        if (wd[B_WST_LO+1]) wakeStQ[1] <= 1'b0;
        if (wd[B_ERR])      accErrQ    <= 1'b0;
      end
      if (strb.intWr && wd[0]) begin
        pmeIntQ <= 1'b0;
        pme     <= 1'b0;
      end
      if (strb.wake)  modeQ   <= MODE_ON;
      if (strb.badWr) accErrQ <= 1'b1;
      if (strb.detect) begin
        wakeStQ <= 2'b01;
        pmeIntQ <= 1'b1;
        if (edEnQ && pmeEnQ) pme <= 1'b1;
      end
    end
  end

  always_comb begin
    hostRdData = '0;
    if (hostAddr == ADDR_W'(REG_CTRL)) begin
      hostRdData[1:0]               = modeQ;
      hostRdData[B_ED_EN]           = edEnQ;
      hostRdData[B_PME_EN]          = pmeEnQ;
      hostRdData[B_READY]           = ready;
      hostRdData[B_WST_LO+1:B_WST_LO] = wakeStQ;
      hostRdData[B_ERR]             = accErrQ;
    end else if (hostAddr == ADDR_W'(REG_INT)) begin
      hostRdData[0] = pmeIntQ;
    end
  end
endmodule

// File: rtl/netPwrSeq.sv
module netPwrSeq
  import pwrSeqPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int WAKE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              carrierIn,
  output logic              macClkEn,
  output logic              hostClkEn,
  output logic              phyLowPwr,
  output logic              pme,
  output logic              ready
);
  pwrStrobes_t strb;
  logic        carrierSync;
  logic [1:0]  modeQ, wakeStQ;
  logic        edEnQ, pmeEnQ, pmeIntQ, accErrQ;

  carrierSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(carrierIn), .syncOut(carrierSync)
  );

  pwrSeqCtrl #(.ADDR_W(ADDR_W), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .wrMode(hostWrData[1:0]), .carrierSync(carrierSync), .strb(strb),
    .ready(ready), .macClkEn(macClkEn), .hostClkEn(hostClkEn),
    .phyLowPwr(phyLowPwr)
  );

  pwrSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .ready(ready),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .pme(pme), .modeQ(modeQ), .edEnQ(edEnQ), .pmeEnQ(pmeEnQ),
    .pmeIntQ(pmeIntQ), .accErrQ(accErrQ), .wakeStQ(wakeStQ)
  );
endmodule

// File: rtl/pwrSeqChecker.sv
module pwrSeqChecker
  import pwrSeqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              ready,
  input logic              macClkEn,
  input logic              phyLowPwr,
  input logic              pme,
  input logic [1:0]        modeQ,
  input logic              edEnQ,
  input logic              pmeEnQ,
  input logic              pmeIntQ,
  input logic              accErrQ
);
  // R2
  entry_from_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyLowPwr) |-> $past(ready) && !ready);

  // R3
  wol_no_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !macClkEn && !phyLowPwr) |=> !$rose(pmeIntQ));

  // R6
  pme_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pme) |-> edEnQ && pmeEnQ && pmeIntQ);

  // R7
  wake_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (modeQ == MODE_ON) && macClkEn);

  // R8
  bad_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !ready && hostAddr != ADDR_W'(REG_WAKE)) |=> accErrQ);

  // R9
  pme_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    pme |-> pmeIntQ);
endmodule

bind netPwrSeq pwrSeqChecker #(.ADDR_W(ADDR_W)) u_pwrSeqChecker (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .ready(ready), .macClkEn(macClkEn), .phyLowPwr(phyLowPwr), .pme(pme),
  .modeQ(modeQ), .edEnQ(edEnQ), .pmeEnQ(pmeEnQ), .pmeIntQ(pmeIntQ),
  .accErrQ(accErrQ)
);

// File: tb/test_netPwrSeq.sv
`timescale 1ns/1ps
module test_netPwrSeq;
  localparam int ADDR_W = 4, DATA_W = 8, WAKE_CYCLES = 8, SYNC_STAGES = 2;

  logic clk = 1'b0, rstN = 1'b0, hostWrEn = 1'b0, carrierIn = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWrData = '0, hostRdData;
  logic macClkEn, hostClkEn, phyLowPwr, pme, ready;
  int totalCnt = 0, failCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  netPwrSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAKE_CYCLES(WAKE_CYCLES),
              .SYNC_STAGES(SYNC_STAGES)) i_netPwrSeq (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .carrierIn(carrierIn),
    .macClkEn(macClkEn), .hostClkEn(hostClkEn), .phyLowPwr(phyLowPwr),
    .pme(pme), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = ADDR_W'(addr); hostWrData = data;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
  endtask

  task automatic rd(input int addr, output logic [7:0] data);
    hostAddr = ADDR_W'(addr);
    #1 data = hostRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // outputs packed {ready, macClkEn, hostClkEn, phyLowPwr, pme}
  function automatic logic [4:0] outs();
    return {ready, macClkEn, hostClkEn, phyLowPwr, pme};
  endfunction

  task automatic wakeAndWait(input string req);
    logic [7:0] d;
    wr(2, 8'h00);
    check({req, " clocks on after wake"}, {27'd0, outs()}, 32'b01100 | {31'd0, pme});
    rd(0, d);
    check({req, " mode 00 after wake"}, {30'd0, d[1:0]}, 0);
    waitCyc(WAKE_CYCLES - 1);
    check({req, " ready still low one edge early"}, {31'd0, ready}, 0);
    waitCyc(1);
    check({req, " ready back"}, {31'd0, ready}, 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 ctrl reset", {24'd0, d}, 32'h10);
    rd(1, d); check("R1 int reset", {24'd0, d}, 0);
    check("R1 outputs reset", {27'd0, outs()}, 32'b11100);
  endtask

  task automatic t_edSleep();
    logic [7:0] d;
    wr(0, 8'h0E);
    check("R2 outputs in energy-detect sleep", {27'd0, outs()}, 32'b00010);
    rd(0, d); check("R2 ctrl in sleep", {24'd0, d}, 32'h0E);
    carrierIn = 1'b1;
    waitCyc(SYNC_STAGES);
    rd(1, d); check("R4 no detect before sync delay", {24'd0, d}, 0);
    waitCyc(1);
    rd(1, d); check("R4 interrupt set on detect", {24'd0, d}, 1);
    rd(0, d); check("R4 wake status 01", {30'd0, d[6:5]}, 1);
    check("R6 pme with both enables", {31'd0, pme}, 1);
    wr(0, 8'h61);
    rd(0, d); check("R8 write dropped and error set", {24'd0, d}, 32'hAE);
    wr(1, 8'h01);
    rd(1, d); check("R8 int write dropped", {24'd0, d}, 1);
    wakeAndWait("R7");
    rd(0, d); check("R8 error sticky after wake", {24'd0, d}, 32'hBC);
    wr(0, 8'hEC);
    rd(0, d); check("R9 w1c status and error", {24'd0, d}, 32'h1C);
    check("R9 pme kept until int clear", {31'd0, pme}, 1);
    wr(1, 8'h01);
    rd(1, d); check("R9 int cleared", {24'd0, d}, 0);
    check("R9 pme dropped", {31'd0, pme}, 0);
    carrierIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic t_carrierPresent();
    logic [7:0] d;
    carrierIn = 1'b1;
    waitCyc(4);
    wr(0, 8'h06);
    rd(1, d); check("R5 not yet detected at entry", {24'd0, d}, 0);
    waitCyc(1);
    rd(1, d); check("R5 detected one edge after entry", {24'd0, d}, 1);
    check("R6 no pme with pme enable low", {31'd0, pme}, 0);
    wakeAndWait("R7 second wake");
    wr(0, 8'h60); wr(1, 8'h01);
    carrierIn = 1'b0;
    waitCyc(4);
  endtask

  task automatic t_wol();
    logic [7:0] d;
    wr(0, 8'h0D);
    check("R3 outputs in wake-on-LAN sleep", {27'd0, outs()}, 32'b00000);
    carrierIn = 1'b1;
    waitCyc(6);
    rd(1, d); check("R3 no interrupt from carrier", {24'd0, d}, 0);
    rd(0, d); check("R3 ctrl unchanged", {24'd0, d}, 32'h0D);
    carrierIn = 1'b0;
    wakeAndWait("R7 from wol");
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(0, 8'h03);
    check("R10 stays in normal operation", {27'd0, outs()}, 32'b11100);
    rd(0, d); check("R10 mode reads 00", {24'd0, d}, 32'h10);
    wr(2, 8'hFF);
    waitCyc(2);
    check("R11 wake write in normal has no effect", {27'd0, outs()}, 32'b11100);
    rd(0, d); check("R11 ctrl unchanged", {24'd0, d}, 32'h10);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    t_reset();
    t_edSleep();
    t_carrierPresent();
    t_wol();
    t_reserved();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      totalCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule